// File: doc/BRIEF.md
# Glitch-free clock power-down gate

This block sits between a set of free-running source clocks and the output buffers of a clock generator. When the active-low power-down request `pd_n` goes low, every output is parked at a defined level. Each output changes only on one of its own source edges, so no shortened pulse leaves the block. When `pd_n` returns high, every output starts following its source again, also on a source edge. The request is asynchronous. It counts only after it has been synchronised and then seen low on two consecutive rising edges of the complement clock of CPU pair 0.

There are two kinds of output. Single-ended clocks park low. Differential true/complement pairs park with the true leg high and the complement leg low. Each pair also has a drive-mode bit. With the bit at 0, the true leg keeps driving high during power-down. With the bit at 1, both legs are released to high impedance. All CPU pairs share one drive-mode bit, and all SRC pairs share another. The output enables are separate ports, so the pad ring can apply the tristate choice.

Top module: `clkpd_gate`

## Requirements
- R1: A low on `pd_n` stops the clocks only after it has passed a two-flop synchroniser clocked by the rising edge of `dp_c_src_i[0]` and has then been seen low on two consecutive such rising edges. A low pulse shorter than one period of that clock never stops any output.
- R2: Once a stop has been qualified, each single-ended output `se_clk_o[i]` is forced to 0, starting at the next falling edge of `se_src_i[i]`. It stays 0 for as long as the stop lasts, and no high pulse of it is ever shorter than half its source period.
- R3: Once a stop has been qualified, each pair parks at the next falling edge of its complement source. While parked, `dp_t_o[i]` is 1 and `dp_c_o[i]` is 0. No pulse of `dp_t_o[i]` is ever shorter than half its source period.
- R4: While a pair is parked with its drive-mode bit at 0, `dp_t_oe[i]` is 1 and `dp_c_oe[i]` is 0: the true leg is driven high and the complement leg floats.
- R5: While a pair is parked with its drive-mode bit at 1, both `dp_t_oe[i]` and `dp_c_oe[i]` are 0.
- R6: Pairs 0 to NUM_CPU-1 take their drive mode from `cpu_tri_i`, and the remaining pairs take it from `src_tri_i`. The bit is read live, so a change during power-down takes effect at once. While a pair is running, the bit has no effect.
- R7: After `pd_n` returns high, every output resumes following its source with all enables at 1. Each output resumes at a falling edge of its own source (the complement source for a pair), so no runt pulse appears.
- R8: While `rst_n` is low, every output follows its source and every enable is 1.
- R9: While not stopped, `se_clk_o`, `dp_t_o` and `dp_c_o` equal `se_src_i`, `dp_t_src_i` and `dp_c_src_i` exactly, and all enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside each clock domain |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| se_src_i | input | NUM_SE | Single-ended source clocks |
| dp_t_src_i | input | NUM_DP | True source clock of each pair |
| dp_c_src_i | input | NUM_DP | Complement source clock of each pair; bit 0 also qualifies the request |
| cpu_tri_i | input | 1 | Drive mode of the CPU pairs (0 drive true high, 1 tristate both legs) |
| src_tri_i | input | 1 | Drive mode of the SRC pairs (same encoding) |
| se_clk_o | output | NUM_SE | Gated single-ended clocks |
| dp_t_o | output | NUM_DP | Gated true clocks |
| dp_c_o | output | NUM_DP | Gated complement clocks |
| dp_t_oe | output | NUM_DP | Output enable of each true leg |
| dp_c_oe | output | NUM_DP | Output enable of each complement leg |

## Verification
Two situations are hard to reach from the ports. The first is the rejection of a request that is too brief: `pd_n` is pulsed low for 2 ns, less than one qualifying period, and the bench then watches every output for 200 ns to confirm that nothing parked. The second is a stop or restart that lands on a source edge and would leave a runt. To reach it, every source runs at its own period and phase, and a seeded random sequence of power-down lengths, idle gaps and drive-mode settings drives the block. Monitors measure every high and low interval of each single-ended output and each true leg, and flag any interval shorter than half the source period.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

  // Park behaviour of a differential pair while powered down.
  typedef enum logic {
    PARK_DRIVE_HIGH = 1'b0,
    PARK_TRISTATE   = 1'b1
  } park_mode_e;

  // Minimum synchroniser depth accepted by the design.
  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/clkpd_sync.sv
// Multi-flop synchroniser with asynchronous reset to a selectable level.
module clkpd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  import clkpd_pkg::*;

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] stg_q;
  logic [LAST:0] stg_d;

  initial begin
    if (STAGES < MIN_SYNC_STAGES) $error("clkpd_sync: STAGES below minimum");
  end

  always_comb begin
    stg_d = {stg_q[LAST-1:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[LAST];

endmodule

// File: rtl/clkpd_qual.sv
// Qualifies the asynchronous power-down request in the qualifying clock
// domain: synchronised, then low on two consecutive rising edges.
module clkpd_qual #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic qclk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  output logic stop_o
);

  logic rst_q;
  logic pd_s;
  logic pd_prev_q, pd_prev_d;
  logic stop_q, stop_d;

  // Reset: asserted asynchronously, released on a qualifying edge.
  clkpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (qclk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_q)
  );

  // Request synchroniser resets to "not powered down".
  clkpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i (qclk_i),
    .rst_ni(rst_q),
    .d_i   (pd_ni),
    .q_o   (pd_s)
  );

  always_comb begin
    pd_prev_d = pd_s;
    stop_d    = !pd_s && !pd_prev_q;
  end

  always_ff @(posedge qclk_i or negedge rst_q) begin
    if (!rst_q) begin
      pd_prev_q <= 1'b1;
      stop_q    <= 1'b0;
    end else begin
      pd_prev_q <= pd_prev_d;
      stop_q    <= stop_d;
    end
  end

  assign stop_o = stop_q;

  // A stop may only begin after two consecutive low synchronised samples.
  AST_QUAL_TWO_LOW: assert property (@(posedge qclk_i) disable iff (!rst_q)
    $rose(stop_q) |-> (!$past(pd_s, 1) && !$past(pd_s, 2))); // R1

  // A high synchronised sample ends the stop on the next edge.
  AST_QUAL_RELEASE: assert property (@(posedge qclk_i) disable iff (!rst_q)
    $past(pd_s) |-> !stop_q); // R7

endmodule

// File: rtl/clkpd_se_cell.sv
// Gate for one single-ended clock: parks low, switching on falling edges.
module clkpd_se_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic src_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic clk_o
);

  logic rst_q;
  logic req_s;
  logic park_q, park_d;

  clkpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (src_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_q)
  );

  clkpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk_i (src_i),
    .rst_ni(rst_q),
    .d_i   (stop_i),
    .q_o   (req_s)
  );

  always_comb begin
    park_d = req_s;
  end

  // Park state changes only while the source is low.
  always_ff @(negedge src_i or negedge rst_q) begin
    if (!rst_q) begin
      park_q <= 1'b0;
    end else begin
      park_q <= park_d;
    end
  end

  assign clk_o = src_i & ~park_q;

  // The park flop tracks the synchronised request one falling edge later.
  AST_SE_PARK_FOLLOWS: assert property (@(posedge src_i) disable iff (!rst_q)
    park_q |-> req_s); // R2

endmodule

// File: rtl/clkpd_dp_cell.sv
// Gate for one true/complement pair: parks true-high on a complement
// falling edge, with a drive-high or tristate park state.
module clkpd_dp_cell
  import clkpd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       src_t_i,
  input  logic       src_c_i,
  input  logic       rst_ni,
  input  logic       stop_i,
  input  park_mode_e mode_i,
  output logic       t_o,
  output logic       c_o,
  output logic       t_oe_o,
  output logic       c_oe_o
);

  logic rst_q;
  logic req_s;
  logic park_q, park_d;

  clkpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (src_c_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_q)
  );

  clkpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk_i (src_c_i),
    .rst_ni(rst_q),
    .d_i   (stop_i),
    .q_o   (req_s)
  );

  always_comb begin
    park_d = req_s;
  end

  // Complement falling edge: complement is low and true is high.
  always_ff @(negedge src_c_i or negedge rst_q) begin
    if (!rst_q) begin
      park_q <= 1'b0;
    end else begin
      park_q <= park_d;
    end
  end

  always_comb begin
    if (park_q) begin
      t_o    = 1'b1;
      c_o    = 1'b0;
      t_oe_o = (mode_i == PARK_DRIVE_HIGH);
      c_oe_o = 1'b0;
    end else begin
      t_o    = src_t_i;
      c_o    = src_c_i;
      t_oe_o = 1'b1;
      c_oe_o = 1'b1;
    end
  end

  AST_DP_PARK_FOLLOWS: assert property (@(posedge src_c_i) disable iff (!rst_q)
    park_q |-> req_s); // R3

  AST_DP_COMP_RELEASED: assert property (@(posedge src_c_i) disable iff (!rst_q)
    park_q |-> (!c_oe_o && t_o)); // R4

  AST_DP_TRISTATE_BOTH: assert property (@(posedge src_c_i) disable iff (!rst_q)
    (park_q && mode_i == PARK_TRISTATE) |-> (!t_oe_o && !c_oe_o)); // R5

endmodule

// File: rtl/clkpd_gate.sv
// Top: power-down qualification plus one gate cell per output clock.
module clkpd_gate
  import clkpd_pkg::*;
#(
  parameter int unsigned NUM_SE      = 3,
  parameter int unsigned NUM_CPU     = 2,
  parameter int unsigned NUM_SRC     = 1,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_DP     = NUM_CPU + NUM_SRC
) (
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic [NUM_SE-1:0] se_src_i,
  input  logic [NUM_DP-1:0] dp_t_src_i,
  input  logic [NUM_DP-1:0] dp_c_src_i,
  input  logic              cpu_tri_i,
  input  logic              src_tri_i,
  output logic [NUM_SE-1:0] se_clk_o,
  output logic [NUM_DP-1:0] dp_t_o,
  output logic [NUM_DP-1:0] dp_c_o,
  output logic [NUM_DP-1:0] dp_t_oe,
  output logic [NUM_DP-1:0] dp_c_oe
);

  logic stop_w;

  clkpd_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .qclk_i(dp_c_src_i[0]),
    .rst_ni(rst_n),
    .pd_ni (pd_n),
    .stop_o(stop_w)
  );

  for (genvar g = 0; g < NUM_SE; g++) begin : g_se
    clkpd_se_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .src_i (se_src_i[g]),
      .rst_ni(rst_n),
      .stop_i(stop_w),
      .clk_o (se_clk_o[g])
    );
  end

  for (genvar g = 0; g < NUM_DP; g++) begin : g_dp
    park_mode_e mode_w;
    if (g < NUM_CPU) begin : g_cpu_mode
      assign mode_w = park_mode_e'(cpu_tri_i);
    end else begin : g_src_mode
      assign mode_w = park_mode_e'(src_tri_i);
    end

    clkpd_dp_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .src_t_i(dp_t_src_i[g]),
      .src_c_i(dp_c_src_i[g]),
      .rst_ni (rst_n),
      .stop_i (stop_w),
      .mode_i (mode_w),
      .t_o    (dp_t_o[g]),
      .c_o    (dp_c_o[g]),
      .t_oe_o (dp_t_oe[g]),
      .c_oe_o (dp_c_oe[g])
    );
  end

endmodule

// File: tb/clkpd_gate_test.sv
`timescale 1ns/10ps
module clkpd_gate_test;

  localparam int NUM_SE  = 3;
  localparam int NUM_CPU = 2;
  localparam int NUM_SRC = 1;
  localparam int NUM_DP  = NUM_CPU + NUM_SRC;
  localparam int WATCHDOG_CYCLES = 150000;

  // Half periods and phase offsets of every source (ns), chosen so no
  // source edge lands on an integer time where the bench samples.
  localparam real SE_HALF [NUM_SE] = '{4.0, 7.0, 10.0};
  localparam real SE_OFS  [NUM_SE] = '{0.7, 1.1, 1.5};
  localparam real DP_HALF [NUM_DP] = '{3.0, 3.75, 5.0};
  localparam real DP_OFS  [NUM_DP] = '{0.3, 0.45, 0.9};

  logic clk = 1'b0;
  logic rst_n;
  logic pd_n;
  logic [NUM_SE-1:0] se_src = '0;
  logic [NUM_DP-1:0] dp_t_src = '0;
  logic [NUM_DP-1:0] dp_c_src;
  logic cpu_tri, src_tri;
  logic [NUM_SE-1:0] se_clk_o;
  logic [NUM_DP-1:0] dp_t_o, dp_c_o, dp_t_oe, dp_c_oe;

  int checks = 0;
  int failures = 0;
  int runts = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  assign dp_c_src = ~dp_t_src;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NUM_SE; g++) begin : g_se_src
    initial begin
      #(SE_OFS[g]);
      forever #(SE_HALF[g]) se_src[g] = ~se_src[g];
    end
  end

  for (genvar g = 0; g < NUM_DP; g++) begin : g_dp_src
    initial begin
      #(DP_OFS[g]);
      forever #(DP_HALF[g]) dp_t_src[g] = ~dp_t_src[g];
    end
  end

  clkpd_gate #(.NUM_SE(NUM_SE), .NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) uut (
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .se_src_i  (se_src),
    .dp_t_src_i(dp_t_src),
    .dp_c_src_i(dp_c_src),
    .cpu_tri_i (cpu_tri),
    .src_tri_i (src_tri),
    .se_clk_o  (se_clk_o),
    .dp_t_o    (dp_t_o),
    .dp_c_o    (dp_c_o),
    .dp_t_oe   (dp_t_oe),
    .dp_c_oe   (dp_c_oe)
  );

  // Runt monitors (R2, R3, R7): every interval >= half source period.
  for (genvar g = 0; g < NUM_SE; g++) begin : g_se_mon
    realtime last = 0.0;
    always @(se_clk_o[g]) begin
      if (mon_on && ($realtime - last) < SE_HALF[g] - 0.05) begin
        runts++;
        $display("FAIL [R2] runt on se_clk_o[%0d] actual=%0.2f expected>=%0.2f",
                 g, $realtime - last, SE_HALF[g]);
      end
      last = $realtime;
    end
  end

  for (genvar g = 0; g < NUM_DP; g++) begin : g_dp_mon
    realtime last = 0.0;
    always @(dp_t_o[g]) begin
      if (mon_on && ($realtime - last) < DP_HALF[g] - 0.05) begin
        runts++;
        $display("FAIL [R3] runt on dp_t_o[%0d] actual=%0.2f expected>=%0.2f",
                 g, $realtime - last, DP_HALF[g]);
      end
      last = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL [%s] %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected true-leg enable while parked: 1 for drive-high mode.
  function automatic logic [NUM_DP-1:0] exp_park_toe(input logic c_tri, input logic s_tri);
    logic [NUM_DP-1:0] v;
    for (int i = 0; i < NUM_DP; i++) v[i] = (i < NUM_CPU) ? !c_tri : !s_tri;
    return v;
  endfunction

  task automatic chk_run(input string req, input int n);
    int bad_se = 0, bad_t = 0, bad_c = 0, bad_oe = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (se_clk_o !== se_src) bad_se++;
      if (dp_t_o !== dp_t_src) bad_t++;
      if (dp_c_o !== dp_c_src) bad_c++;
      if (dp_t_oe !== '1 || dp_c_oe !== '1) bad_oe++;
    end
    check(bad_se == 0, req, "se_clk_o vs source mismatches", bad_se, 0);
    check(bad_t == 0, req, "dp_t_o vs source mismatches", bad_t, 0);
    check(bad_c == 0, req, "dp_c_o vs source mismatches", bad_c, 0);
    check(bad_oe == 0, req, "enables not all 1", bad_oe, 0);
  endtask

  task automatic chk_park(input string req_lvl, input string req_oe, input int n);
    logic [NUM_DP-1:0] exp_toe;
    int bad_se = 0, bad_t = 0, bad_c = 0, bad_toe = 0, bad_coe = 0;
    logic [NUM_DP-1:0] last_toe = '0;
    exp_toe = exp_park_toe(cpu_tri, src_tri);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (se_clk_o !== '0) bad_se++;
      if (dp_t_o !== '1) bad_t++;
      if (dp_c_o !== '0) bad_c++;
      if (dp_t_oe !== exp_toe) begin bad_toe++; last_toe = dp_t_oe; end
      if (dp_c_oe !== '0) bad_coe++;
    end
    check(bad_se == 0, "R2", "se_clk_o not held low", bad_se, 0);
    check(bad_t == 0, req_lvl, "dp_t_o not held high", bad_t, 0);
    check(bad_c == 0, req_lvl, "dp_c_o not held low", bad_c, 0);
    check(bad_toe == 0, req_oe, "dp_t_oe wrong", int'(last_toe), int'(exp_toe));
    check(bad_coe == 0, "R4", "dp_c_oe not 0", bad_coe, 0);
  endtask

  task automatic finish_run();
    check(runts == 0, "R7", "runt pulses seen", runts, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > WATCHDOG_CYCLES && !done) begin
        done = 1'b1;
        checks++;
        failures++;
        $display("FAIL [R7] watchdog expired actual=%0d expected<=%0d", wd, WATCHDOG_CYCLES);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1C));
    rst_n = 1'b0;
    pd_n = 1'b1;
    cpu_tri = 1'b0;
    src_tri = 1'b1;

    // R8: reset state passes sources through with all enables high.
    #60;
    chk_run("R8", 20);
    // R8: a power-down request during reset has no effect.
    pd_n = 1'b0;
    chk_run("R8", 20);
    pd_n = 1'b1;
    #4;

    @(negedge clk);
    rst_n = 1'b1;
    #100;
    mon_on = 1'b1;
    chk_run("R9", 30);

    // R1: a 2 ns low pulse, shorter than one qualifying period.
    @(negedge clk);
    pd_n = 1'b0;
    #2;
    pd_n = 1'b1;
    chk_run("R1", 50);

    // R1: a held low request stops everything; R4 CPU drive, R5 SRC tristate.
    cpu_tri = 1'b0;
    src_tri = 1'b1;
    @(negedge clk);
    pd_n = 1'b0;
    #250;
    chk_park("R3", "R5", 10);
    // R6: the mode bits are live while parked.
    cpu_tri = 1'b1;
    src_tri = 1'b0;
    #10;
    chk_park("R3", "R6", 10);
    // R7: restart.
    @(negedge clk);
    pd_n = 1'b1;
    #200;
    chk_run("R7", 20);

    // R6: mode bits change while running and must have no effect.
    cpu_tri = 1'b1;
    src_tri = 1'b1;
    chk_run("R6", 10);

    // Random power-down sessions with random modes and lengths.
    for (int it = 0; it < 10; it++) begin
      int lo_ns, hi_ns;
      cpu_tri = 1'($urandom_range(0, 1));
      src_tri = 1'($urandom_range(0, 1));
      lo_ns = 250 + int'($urandom_range(0, 150));
      hi_ns = 200 + int'($urandom_range(0, 100));
      #($urandom_range(0, 7));
      pd_n = 1'b0;
      #(lo_ns);
      chk_park("R3", (cpu_tri || src_tri) ? "R5" : "R4", 8);
      #($urandom_range(0, 5));
      pd_n = 1'b1;
      #(hi_ns);
      chk_run("R7", 8);
    end

    done = 1'b1;
    finish_run();
  end

endmodule